// File: doc/BRIEF.md
# Descriptor Ring Read DMA Pointer Engine

This block is the control side of a scatter-gather receive DMA. Software arms a circular ring of descriptor tables in memory; every table holds the same number of 128-bit region descriptors. Each descriptor names a destination address, a byte count, an end-of-table flag and a per-entry completion-interrupt request. When a data frame arrives as a byte stream, the engine fetches the descriptors of the table at the head of the ring one at a time. For each region it uses, it emits one memory-write command that carries the region's address and the number of bytes placed there.

When the frame is done, the engine advances a hardware read pointer. Bit 7 of that pointer is a wrap-parity bit. The engine also sets a sticky end-of-frame status and, if enabled, pulses an interrupt. Software owns the write pointer. The ring is empty when the two pointers are equal, and no frame is started then. It is full when they differ only in bit 7. Bytes that arrive after the table's capacity is used up are absorbed and discarded, and an overflow status is set.

Top module: `desc_ring_rdma`

## Requirements
- R1: After a synchronous active-high reset, `hw_rd_ptr` is 00h, and `desc_req`, `pl_ready`, `wr_cmd_valid`, `ent_irq`, `eof_irq`, `eof_sts` and `ovf_sts` are all 0.
- R2: The descriptor for entry e of the table at the ring head is requested at `cfg_ring_base + (hw_rd_ptr[6:0] * (cfg_ents_m1 + 1) + e) * 16`. Entries are fetched in increasing order starting at entry 0 for every frame.
- R3: On each end of frame the read pointer moves to the next value. If `hw_rd_ptr[6:0]` is already at or above `cfg_depth_m1`, the next value has bits 6:0 cleared and bit 7 inverted. Otherwise the next value is the pointer plus one. For `cfg_depth_m1` = 3 the sequence is 00h, 01h, 02h, 03h, 80h, 81h, 82h, 83h, 00h. The pointer changes at no other time.
- R4: `desc_req` stays high with a stable `desc_addr` until `desc_vld` is seen.
- R5: While `hw_rd_ptr` equals `sw_wr_ptr`, no frame is started: `pl_ready` and `desc_req` stay low. A full ring (the pointers differ only in bit 7) still accepts frames.
- R6: The descriptor fields are decoded as follows: bits 53:0 are the destination address, bit 63 is the completion-interrupt request, bits 87:64 are the byte length, and bit 88 is end-of-table. Bits 90:89 (hardware status) and all other bits are ignored. For every entry that receives bytes, exactly one write command is emitted, with `wr_cmd_addr` equal to the destination and `wr_cmd_len` equal to the bytes placed in that entry.
- R7: A frame ends at the byte flagged `pl_last`, or when an entry that is the last of its table is used up, whichever comes first. An entry is the last of its table when its end-of-table bit is set or its index equals `cfg_ents_m1`. Entries of length zero receive no bytes and produce no command.
- R8: At each end of frame, `eof_sts` is set and `eof_irq` pulses for one cycle only if `eof_int_en` is 1.
- R9: Bytes of a frame that arrive after its table is used up are accepted, dropped and produce no command, and they set `ovf_sts`.
- R10: `ent_irq` pulses together with the write command of an entry whose completion-interrupt bit is set.
- R11: `sts_clr[0]` clears `eof_sts` and `sts_clr[1]` clears `ovf_sts`. A new event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ring_base | input | BASE_W | Byte address of table 0, entry 0 |
| cfg_depth_m1 | input | 7 | Number of tables in the ring minus one |
| cfg_ents_m1 | input | ENT_W | Entries per table minus one |
| sw_wr_ptr | input | 8 | Software write pointer, bit 7 is wrap parity |
| eof_int_en | input | 1 | Enables the end-of-frame interrupt pulse |
| sts_clr | input | 2 | Bit 0 clears end-of-frame status, bit 1 clears overflow status |
| desc_req | output | 1 | Descriptor fetch request |
| desc_addr | output | BASE_W | Descriptor fetch byte address |
| desc_vld | input | 1 | Descriptor response valid |
| desc_data | input | 128 | Descriptor response word |
| pl_valid | input | 1 | Payload byte present |
| pl_last | input | 1 | Current payload byte ends the frame |
| pl_ready | output | 1 | Payload byte accepted when high with `pl_valid` |
| wr_cmd_valid | output | 1 | Write command pulse |
| wr_cmd_addr | output | 54 | Write command destination address |
| wr_cmd_len | output | 24 | Write command byte count |
| ent_irq | output | 1 | Completion-interrupt pulse of an entry |
| hw_rd_ptr | output | 8 | Hardware read pointer, bit 7 is wrap parity |
| eof_sts | output | 1 | Sticky end-of-frame status |
| ovf_sts | output | 1 | Sticky overflow status |
| eof_irq | output | 1 | End-of-frame interrupt pulse |

## Verification
Several properties are checked on every cycle. The read pointer holds still outside end-of-frame processing. A pending descriptor request keeps its address. An empty ring keeps the sequencer idle. No write command is longer than its descriptor. The interrupt pulse never appears without the status bit, and a clear lands when no new event competes with it. The values the engine produces can only be shown by the bench's frames: the exact descriptor addresses, the split of a frame across entries, the wrap pattern of the pointer, zero-length and count-limited tables, and the overflow drop. Each of these is compared with a model of the ring walk kept in the bench.

// File: rtl/dring_pkg.sv
package dring_pkg;

    localparam int DADDR_W = 54;
    localparam int DLEN_W  = 24;
    localparam int PTR_W   = 8;
    localparam int TBL_W   = PTR_W - 1;
    localparam int DESC_W  = 128;

    typedef struct packed {
        logic [DADDR_W-1:0] dest;
        logic               ioc;
        logic [DLEN_W-1:0]  len;
        logic               eot;
    } desc_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_XFER,
        S_EOF,
        S_DRAIN
    } seq_st_t;

    function automatic desc_t desc_unpack(input logic [DESC_W-1:0] w);
        desc_t d;
        d.dest = w[53:0];
        d.ioc  = w[63];
        d.len  = w[87:64];
        d.eot  = w[88];
        return d;
    endfunction

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p,
                                                  input logic [TBL_W-1:0] dm1);
        if (p[TBL_W-1:0] >= dm1)
            return {~p[PTR_W-1], {TBL_W{1'b0}}};
        return p + PTR_W'(1);
    endfunction

endpackage

// File: rtl/dring_ptr.sv
module dring_ptr
    import dring_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    input  logic [TBL_W-1:0] depth_m1,
    input  logic [PTR_W-1:0] sw_wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             empty
);

    always_ff @(posedge clk) begin
        if (rst)
            rd_ptr <= '0;
        else if (adv)
            rd_ptr <= ptr_next(rd_ptr, depth_m1);
    end

    assign empty = (rd_ptr == sw_wr_ptr);

    // R3: pointer moves only on an end-of-frame advance
    a_r3_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(rd_ptr));

endmodule

// File: rtl/dring_stat.sv
module dring_stat (
    input  logic       clk,
    input  logic       rst,
    input  logic       eof_evt,
    input  logic       drop_evt,
    input  logic       eof_en,
    input  logic [1:0] sts_clr,
    output logic       eof_sts,
    output logic       ovf_sts,
    output logic       irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            eof_sts <= 1'b0;
            ovf_sts <= 1'b0;
            irq     <= 1'b0;
        end else begin
            irq <= eof_evt & eof_en;
            if (eof_evt)
                eof_sts <= 1'b1;
            else if (sts_clr[0])
                eof_sts <= 1'b0;
            if (drop_evt)
                ovf_sts <= 1'b1;
            else if (sts_clr[1])
                ovf_sts <= 1'b0;
        end
    end

    // R8: interrupt pulse always comes with the status bit
    a_r8_irq_has_sts: assert property (@(posedge clk) disable iff (rst)
        irq |-> eof_sts);

    // R11: an uncontested clear empties the end-of-frame status
    a_r11_clear: assert property (@(posedge clk) disable iff (rst)
        (sts_clr[0] && !eof_evt) |=> !eof_sts);

endmodule

// File: rtl/dring_seq.sv
module dring_seq
    import dring_pkg::*;
#(
    parameter int BASE_W = 64,
    parameter int ENT_W  = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ring_empty,
    input  logic [TBL_W-1:0]    tbl,
    input  logic [BASE_W-1:0]   cfg_base,
    input  logic [ENT_W-1:0]    cfg_ents_m1,
    output logic                desc_req,
    output logic [BASE_W-1:0]   desc_addr,
    input  logic                desc_vld,
    input  logic [DESC_W-1:0]   desc_data,
    input  logic                pl_valid,
    input  logic                pl_last,
    output logic                pl_ready,
    output logic                wr_cmd_valid,
    output logic [DADDR_W-1:0]  wr_cmd_addr,
    output logic [DLEN_W-1:0]   wr_cmd_len,
    output logic                ent_irq,
    output logic                ptr_adv,
    output logic                drop_evt
);

    localparam int IDX_W = TBL_W + ENT_W + 2;

    seq_st_t             st;
    desc_t               cur;
    desc_t               fd;
    logic [ENT_W-1:0]    ent_idx;
    logic [DLEN_W-1:0]   placed;
    logic                drop_pend;
    logic [ENT_W:0]      ents;
    logic [IDX_W-1:0]    idx;
    logic                exhaust;
    logic                tbl_last;
    logic                unused_desc_bits;

    assign ents      = {1'b0, cfg_ents_m1} + (ENT_W+1)'(1);
    assign idx       = IDX_W'(tbl) * IDX_W'(ents) + IDX_W'(ent_idx);
    assign desc_addr = cfg_base + BASE_W'({idx, 4'b0000});
    assign desc_req  = (st == S_FETCH);
    assign pl_ready  = (st == S_XFER) || (st == S_DRAIN);
    assign ptr_adv   = (st == S_EOF);
    assign drop_evt  = (st == S_DRAIN) && pl_valid;

    assign fd       = desc_unpack(desc_data);
    assign exhaust  = (placed + DLEN_W'(1)) == cur.len;
    assign tbl_last = cur.eot || (ent_idx == cfg_ents_m1);

    assign unused_desc_bits = ^{desc_data[127:89], desc_data[62:54]};

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= S_IDLE;
            cur          <= '0;
            ent_idx      <= '0;
            placed       <= '0;
            drop_pend    <= 1'b0;
            wr_cmd_valid <= 1'b0;
            wr_cmd_addr  <= '0;
            wr_cmd_len   <= '0;
            ent_irq      <= 1'b0;
        end else begin
            wr_cmd_valid <= 1'b0;
            ent_irq      <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (!ring_empty && pl_valid) begin
                        ent_idx   <= '0;
                        drop_pend <= 1'b0;
                        st        <= S_FETCH;
                    end
                end
                S_FETCH: begin
                    if (desc_vld) begin
                        cur    <= fd;
                        placed <= '0;
                        if (fd.len != '0) begin
                            st <= S_XFER;
                        end else if (fd.eot || ent_idx == cfg_ents_m1) begin
                            drop_pend <= 1'b1;
                            st        <= S_EOF;
                        end else begin
                            ent_idx <= ent_idx + ENT_W'(1);
                        end
                    end
                end
                S_XFER: begin
                    if (pl_valid) begin
                        placed <= placed + DLEN_W'(1);
                        if (pl_last || exhaust) begin
                            wr_cmd_valid <= 1'b1;
                            wr_cmd_addr  <= cur.dest;
                            wr_cmd_len   <= placed + DLEN_W'(1);
                            ent_irq      <= cur.ioc;
                            if (pl_last) begin
                                st <= S_EOF;
                            end else if (tbl_last) begin
                                drop_pend <= 1'b1;
                                st        <= S_EOF;
                            end else begin
                                ent_idx <= ent_idx + ENT_W'(1);
                                st      <= S_FETCH;
                            end
                        end
                    end
                end
                S_EOF: begin
                    st <= drop_pend ? S_DRAIN : S_IDLE;
                end
                S_DRAIN: begin
                    if (pl_valid && pl_last)
                        st <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R4: a pending fetch keeps its request and address
    a_r4_req_hold: assert property (@(posedge clk) disable iff (rst)
        (desc_req && !desc_vld) |=> (desc_req && $stable(desc_addr)));

    // R5: an empty ring keeps the sequencer idle
    a_r5_empty_idle: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE && ring_empty) |=> (st == S_IDLE));

    // R6: a command never exceeds the length of its descriptor
    a_r6_len_bound: assert property (@(posedge clk) disable iff (rst)
        wr_cmd_valid |-> (wr_cmd_len != '0 && wr_cmd_len <= cur.len));

endmodule

// File: rtl/desc_ring_rdma.sv
module desc_ring_rdma
    import dring_pkg::*;
#(
    parameter int BASE_W = 64,
    parameter int ENT_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [BASE_W-1:0]  cfg_ring_base,
    input  logic [6:0]         cfg_depth_m1,
    input  logic [ENT_W-1:0]   cfg_ents_m1,
    input  logic [7:0]         sw_wr_ptr,
    input  logic               eof_int_en,
    input  logic [1:0]         sts_clr,
    output logic               desc_req,
    output logic [BASE_W-1:0]  desc_addr,
    input  logic               desc_vld,
    input  logic [127:0]       desc_data,
    input  logic               pl_valid,
    input  logic               pl_last,
    output logic               pl_ready,
    output logic               wr_cmd_valid,
    output logic [53:0]        wr_cmd_addr,
    output logic [23:0]        wr_cmd_len,
    output logic               ent_irq,
    output logic [7:0]         hw_rd_ptr,
    output logic               eof_sts,
    output logic               ovf_sts,
    output logic               eof_irq
);

    logic ring_empty;
    logic ptr_adv;
    logic drop_evt;

    dring_ptr u_ptr (
        .clk       (clk),
        .rst       (rst),
        .adv       (ptr_adv),
        .depth_m1  (cfg_depth_m1),
        .sw_wr_ptr (sw_wr_ptr),
        .rd_ptr    (hw_rd_ptr),
        .empty     (ring_empty)
    );

    dring_seq #(
        .BASE_W (BASE_W),
        .ENT_W  (ENT_W)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .ring_empty   (ring_empty),
        .tbl          (hw_rd_ptr[TBL_W-1:0]),
        .cfg_base     (cfg_ring_base),
        .cfg_ents_m1  (cfg_ents_m1),
        .desc_req     (desc_req),
        .desc_addr    (desc_addr),
        .desc_vld     (desc_vld),
        .desc_data    (desc_data),
        .pl_valid     (pl_valid),
        .pl_last      (pl_last),
        .pl_ready     (pl_ready),
        .wr_cmd_valid (wr_cmd_valid),
        .wr_cmd_addr  (wr_cmd_addr),
        .wr_cmd_len   (wr_cmd_len),
        .ent_irq      (ent_irq),
        .ptr_adv      (ptr_adv),
        .drop_evt     (drop_evt)
    );

    dring_stat u_stat (
        .clk      (clk),
        .rst      (rst),
        .eof_evt  (ptr_adv),
        .drop_evt (drop_evt),
        .eof_en   (eof_int_en),
        .sts_clr  (sts_clr),
        .eof_sts  (eof_sts),
        .ovf_sts  (ovf_sts),
        .irq      (eof_irq)
    );

endmodule

// File: tb/desc_ring_rdma_bench.sv
`timescale 1ns/1ps
module desc_ring_rdma_bench;

    localparam logic [63:0] BASE = 64'h0000_0040_8000_0100;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [63:0]  cfg_ring_base = BASE;
    logic [6:0]   cfg_depth_m1 = 7'd3;
    logic [7:0]   cfg_ents_m1 = 8'd3;
    logic [7:0]   sw_wr_ptr = 8'h00;
    logic         eof_int_en = 1'b1;
    logic [1:0]   sts_clr = 2'b00;
    logic         desc_req;
    logic [63:0]  desc_addr;
    logic         desc_vld = 1'b0;
    logic [127:0] desc_data = '0;
    logic         pl_valid = 1'b0;
    logic         pl_last = 1'b0;
    logic         pl_ready;
    logic         wr_cmd_valid;
    logic [53:0]  wr_cmd_addr;
    logic [23:0]  wr_cmd_len;
    logic         ent_irq;
    logic [7:0]   hw_rd_ptr;
    logic         eof_sts;
    logic         ovf_sts;
    logic         eof_irq;

    always #2.5 clk = ~clk;

    desc_ring_rdma u_desc_ring_rdma (
        .clk(clk), .rst(rst), .cfg_ring_base(cfg_ring_base), .cfg_depth_m1(cfg_depth_m1),
        .cfg_ents_m1(cfg_ents_m1), .sw_wr_ptr(sw_wr_ptr), .eof_int_en(eof_int_en),
        .sts_clr(sts_clr), .desc_req(desc_req), .desc_addr(desc_addr), .desc_vld(desc_vld),
        .desc_data(desc_data), .pl_valid(pl_valid), .pl_last(pl_last), .pl_ready(pl_ready),
        .wr_cmd_valid(wr_cmd_valid), .wr_cmd_addr(wr_cmd_addr), .wr_cmd_len(wr_cmd_len),
        .ent_irq(ent_irq), .hw_rd_ptr(hw_rd_ptr), .eof_sts(eof_sts), .ovf_sts(ovf_sts),
        .eof_irq(eof_irq)
    );

    int n_chk = 0;
    int n_err = 0;
    logic [23:0] ent_len [0:255];
    int          eot_ent = 1;
    logic [53:0] q_addr[$];
    logic [23:0] q_len[$];
    logic [63:0] q_fetch[$];
    logic [53:0] x_addr[$];
    logic [23:0] x_len[$];
    logic [63:0] x_fetch[$];
    int          n_irq = 0;
    int          n_eirq = 0;
    int          x_eirq;
    bit          x_drop;
    logic [7:0]  m_rd = 8'h00;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] nxt(input logic [7:0] p, input logic [6:0] dm1);
        if (p[6:0] >= dm1) return {~p[7], 7'd0};
        return p + 8'd1;
    endfunction

    function automatic logic [53:0] dest_of(input int t, input int e);
        return (54'(t) << 20) | (54'(e) << 12) | 54'h5;
    endfunction

    function automatic logic [127:0] desc_word(input logic [63:0] a);
        logic [63:0]  idx;
        logic [127:0] w;
        int ents;
        int e;
        int t;
        idx  = (a - BASE) >> 4;
        ents = int'(cfg_ents_m1) + 1;
        e    = int'(idx % 64'(ents));
        t    = int'(idx / 64'(ents));
        w    = '0;
        w[127:120] = 8'hA5;
        w[53:0]    = dest_of(t, e);
        w[62:54]   = 9'h1FF;
        w[63]      = (e == 0);
        w[87:64]   = ent_len[e];
        w[88]      = (e == eot_ent);
        w[90:89]   = 2'b11;
        return w;
    endfunction

    // descriptor memory responder
    initial begin
        forever begin
            @(negedge clk);
            if (desc_req && !rst) begin
                repeat ($urandom_range(0, 2)) @(negedge clk);
                q_fetch.push_back(desc_addr);
                desc_data = desc_word(desc_addr);
                desc_vld  = 1'b1;
                @(negedge clk);
                desc_vld  = 1'b0;
            end
        end
    end

    // output monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (wr_cmd_valid) begin
                q_addr.push_back(wr_cmd_addr);
                q_len.push_back(wr_cmd_len);
            end
            if (eof_irq) n_irq++;
            if (ent_irq) n_eirq++;
        end
    end

    task automatic send_bytes(input int n);
        @(posedge clk); #1;
        for (int i = 0; i < n; i++) begin
            pl_valid = 1'b1;
            pl_last  = (i == n - 1);
            do @(negedge clk); while (!pl_ready);
            @(posedge clk); #1;
        end
        pl_valid = 1'b0;
        pl_last  = 1'b0;
    endtask

    task automatic run_frame(input int n, input bit en);
        int rem;
        int take;
        int t;
        int ents;
        eof_int_en = en;
        sw_wr_ptr  = m_rd ^ 8'h80;
        t    = int'(m_rd[6:0]);
        ents = int'(cfg_ents_m1) + 1;
        rem  = n;
        x_addr.delete(); x_len.delete(); x_fetch.delete();
        x_drop = 1'b0;
        x_eirq = 0;
        for (int e = 0; e < ents; e++) begin
            x_fetch.push_back(BASE + 64'((t * ents + e) * 16));
            if (ent_len[e] != 24'd0) begin
                take = (int'(ent_len[e]) < rem) ? int'(ent_len[e]) : rem;
                x_addr.push_back(dest_of(t, e));
                x_len.push_back(24'(take));
                if (e == 0) x_eirq++;
                rem -= take;
                if (rem == 0) break;
            end
            if (e == eot_ent || e == ents - 1) begin
                x_drop = (rem > 0);
                break;
            end
        end
        q_addr.delete(); q_len.delete(); q_fetch.delete();
        n_irq  = 0;
        n_eirq = 0;
        send_bytes(n);
        repeat (6) @(negedge clk);
        chk("R2 fetch count", 64'(q_fetch.size()), 64'(x_fetch.size()));
        for (int i = 0; i < x_fetch.size() && i < q_fetch.size(); i++)
            chk("R2 descriptor address", q_fetch[i], x_fetch[i]);
        chk("R6 command count", 64'(q_addr.size()), 64'(x_addr.size()));
        for (int i = 0; i < x_addr.size() && i < q_addr.size(); i++) begin
            chk("R6 command address", 64'(q_addr[i]), 64'(x_addr[i]));
            chk("R7 command length", 64'(q_len[i]), 64'(x_len[i]));
        end
        chk("R3 read pointer step", 64'(hw_rd_ptr), 64'(nxt(m_rd, cfg_depth_m1)));
        chk("R8 end-of-frame status", 64'(eof_sts), 64'd1);
        chk("R8 interrupt pulses", 64'(n_irq), 64'(en));
        chk("R9 overflow status", 64'(ovf_sts), 64'(x_drop));
        chk("R10 entry interrupt pulses", 64'(n_eirq), 64'(x_eirq));
        m_rd = nxt(m_rd, cfg_depth_m1);
        @(posedge clk); #1;
        sts_clr = 2'b11;
        @(posedge clk); #1;
        sts_clr = 2'b00;
        @(negedge clk);
        chk("R11 status cleared", 64'({eof_sts, ovf_sts}), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        bit bad;
        logic [7:0] seq_exp [0:8];
        void'($urandom(32'd4242));
        for (int e = 0; e < 256; e++) ent_len[e] = 24'd8;

        repeat (4) @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 read pointer", 64'(hw_rd_ptr), 64'h0);
        chk("R1 handshakes idle", 64'({desc_req, pl_ready, wr_cmd_valid, ent_irq}), 64'h0);
        chk("R1 status idle", 64'({eof_sts, ovf_sts, eof_irq}), 64'h0);

        // R3 wrap pattern for a four-table ring
        seq_exp = '{8'h01, 8'h02, 8'h03, 8'h80, 8'h81, 8'h82, 8'h83, 8'h00, 8'h01};
        for (int k = 0; k < 9; k++) begin
            run_frame(5, 1'b1);
            chk("R3 wrap sequence", 64'(hw_rd_ptr), 64'(seq_exp[k]));
        end

        // R6 frame split across two entries
        run_frame(12, 1'b1);
        // R9 overflow past the end-of-table entry
        run_frame(20, 1'b1);
        // R7 frame exactly fills the table
        run_frame(16, 1'b1);
        // R8 interrupt disabled
        run_frame(9, 1'b0);
        // R7 zero-length entry skipped
        ent_len[1] = 24'd0;
        eot_ent    = 3;
        run_frame(20, 1'b1);
        // R7 entry-count limit without end-of-table bit
        ent_len[1]  = 24'd8;
        eot_ent     = 99;
        cfg_ents_m1 = 8'd2;
        run_frame(30, 1'b1);
        // R7 zero-length last entry ends the table
        ent_len[2] = 24'd0;
        run_frame(20, 1'b1);
        ent_len[2] = 24'd8;

        // R5 empty ring blocks a frame
        sw_wr_ptr = m_rd;
        pl_valid  = 1'b1;
        bad       = 1'b0;
        repeat (20) begin
            @(negedge clk);
            if (pl_ready || desc_req) bad = 1'b1;
        end
        chk("R5 empty ring blocks frame", 64'(bad), 64'd0);
        chk("R5 pointer held while empty", 64'(hw_rd_ptr), 64'(m_rd));
        @(posedge clk); #1;
        pl_valid = 1'b0;

        // random frames and tables
        cfg_depth_m1 = 7'd5;
        for (int k = 0; k < 30; k++) begin
            cfg_ents_m1 = 8'($urandom_range(0, 5));
            for (int e = 0; e < 6; e++)
                ent_len[e] = (e > 0 && $urandom_range(0, 4) == 0) ? 24'd0 : 24'($urandom_range(1, 12));
            eot_ent = int'($urandom_range(0, 7));
            run_frame(int'($urandom_range(1, 50)), 1'($urandom_range(0, 1)));
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule